// File: doc/BRIEF.md
# Coalescing Writeback Queue

This block is a small holding queue for lines leaving a cache, either as dirty writebacks or as clean-evict notices. It keeps each request until the memory-side port can send it. The queue does not store line data. Each accepted request keeps only a block-aligned address, a secure attribute, a payload handle that points at data held elsewhere, and a sequence number taken from a running counter.

When an entry is sent downstream it becomes in service. When the completion for that entry comes back, the entry is freed. The queue also does two side jobs:
- It compares every new request against the entries it already holds and reports whether the request could be merged into an entry that has not yet been sent.
- It gives a separate blocking controller a full level, plus one-cycle pulses on entry to and exit from the full state.

Capacity is split in two. `PEND_LIMIT` counts entries that are waiting to be sent. `SVC_SPARE` gives extra slots that only in-service entries use. Because of this, sending an entry downstream can lift the block on the access path before its completion arrives.

Top module: `wb_coalesce_q`

## Requirements
- R1: Only command codes 2'b01 (write) and 2'b10 (clean evict) can be allocated. Codes 2'b00 and 2'b11 assert `alloc_bad` in the same cycle, are not accepted, and create no entry.
- R2: The stored and presented address is the request address with its low log2(`BLK_BYTES`) bits cleared. The default is 64-byte blocks.
- R3: While `alloc_valid` is high, `merge_hint` is set when a valid, not-in-service entry has the same aligned address and the same secure bit. `merge_idx` gives the lowest such slot. A match on an in-service entry, or on a different secure bit, gives no hint.
- R4: Accepted allocations receive sequence numbers 0, 1, 2, … counted from reset. Rejected requests use no number.
- R5: A new entry takes the lowest free slot index. `out_valid`/`out_idx` present the not-in-service entry with the lowest sequence number, whatever its slot. `out_issue` marks that entry in service, and it is no longer presented.
- R6: `full` is high when `PEND_LIMIT` entries are waiting or when every slot is occupied. While full, allocation is refused except as allowed by R10. `full_rise` pulses for one cycle after the clock edge that made the queue full.
- R7: `full_fall` pulses for one cycle after an issue or a completion clears the full state.
- R8: `send_kick` is high in exactly the cycles in which an allocation is accepted.
- R9: `done_valid` with the index of an in-service entry frees that slot. A completion naming a waiting or empty slot raises `done_err` and leaves the queue unchanged.
- R10: A request that arrives with a valid completion in the same cycle is accepted when fewer than `PEND_LIMIT` entries are waiting, even if no slot is free; the freed slot is then reused. The full state afterwards reflects only the resulting occupancy, with no extra full indication.
- R11: After reset the queue is empty: `out_valid`, `full`, `full_rise` and `full_fall` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | New writeback or clean-evict request |
| alloc_cmd | input | 2 | Command code of the request |
| alloc_addr | input | ADDR_W | Byte address of the request |
| alloc_secure | input | 1 | Secure attribute of the request |
| alloc_handle | input | HANDLE_W | Payload handle stored with the entry |
| alloc_accept | output | 1 | Request accepted this cycle |
| alloc_bad | output | 1 | Request carries an illegal command |
| merge_hint | output | 1 | A waiting entry holds the same block |
| merge_idx | output | IDX_W | Slot of the lowest matching waiting entry |
| send_kick | output | 1 | Asks the memory side to attempt a send |
| out_valid | output | 1 | A waiting entry is presented |
| out_idx | output | IDX_W | Slot of the presented entry |
| out_addr | output | ADDR_W | Aligned address of the presented entry |
| out_secure | output | 1 | Secure bit of the presented entry |
| out_handle | output | HANDLE_W | Handle of the presented entry |
| out_order | output | ORDER_W | Sequence number of the presented entry |
| out_issue | input | 1 | Presented entry was sent; mark it in service |
| done_valid | input | 1 | Completion for an entry |
| done_idx | input | IDX_W | Slot being completed |
| done_err | output | 1 | Completion named a slot not in service |
| full | output | 1 | Queue refuses new requests |
| full_rise | output | 1 | Queue has just become full |
| full_fall | output | 1 | Queue has just left the full state |

## Verification
The hardest state to reach is a queue that has no free slot even though fewer than `PEND_LIMIT` entries are waiting. To get there, the bench must fill the queue, issue every entry, free only one of them, and refill with a mix of waiting and in-service entries. At that point it offers a request together with a completion, checks that the request is accepted into the slot being freed, and checks that `full` stays as the resulting occupancy dictates. A second path checks that a same-cycle allocate and free does not produce a spurious `full_rise` when a free slot exists. It also checks that the oldest-first choice picks an entry sitting in a higher slot than a younger one.

// File: rtl/wbq_pkg.sv
package wbq_pkg;

   typedef enum logic [1:0] {
      WBQ_CMD_READ  = 2'b00,
      WBQ_CMD_WRITE = 2'b01,
      WBQ_CMD_CLEAN = 2'b10,
      WBQ_CMD_OTHER = 2'b11
   } wbq_cmd_e;

   // Only writes and clean evicts may enter the queue
   function automatic logic wbq_cmd_legal(input logic [1:0] code);
      return (code == WBQ_CMD_WRITE) || (code == WBQ_CMD_CLEAN);
   endfunction

endpackage

// File: rtl/wbq_slots.sv
module wbq_slots #(
   parameter int DEPTH    = 6,
   parameter int IDX_W    = 3,
   parameter int ADDR_W   = 32,
   parameter int HANDLE_W = 8,
   parameter int ORDER_W  = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic                              wr_secure,
   input  logic [HANDLE_W-1:0]               wr_handle,
   input  logic [ORDER_W-1:0]                wr_order,
   input  logic                              svc_en,
   input  logic [IDX_W-1:0]                  svc_idx,
   input  logic                              clr_en,
   input  logic [IDX_W-1:0]                  clr_idx,
   output logic [DEPTH-1:0]                  valid_o,
   output logic [DEPTH-1:0]                  insvc_o,
   output logic [DEPTH-1:0]                  secure_o,
   output logic [DEPTH-1:0][ADDR_W-1:0]      addr_o,
   output logic [DEPTH-1:0][HANDLE_W-1:0]    handle_o,
   output logic [DEPTH-1:0][ORDER_W-1:0]     order_o
);

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic                vld_q;
      logic                svc_q;
      logic                sec_q;
      logic [ADDR_W-1:0]   adr_q;
      logic [HANDLE_W-1:0] hdl_q;
      logic [ORDER_W-1:0]  ord_q;
      logic                hit_wr;
      logic                hit_clr;
      logic                hit_svc;

      assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(s));
      assign hit_clr = clr_en && (clr_idx == IDX_W'(s));
      assign hit_svc = svc_en && (svc_idx == IDX_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            svc_q <= 1'b0;
         end else if (hit_wr) begin
            vld_q <= 1'b1;
            svc_q <= 1'b0;
         end else if (hit_clr) begin
            vld_q <= 1'b0;
            svc_q <= 1'b0;
         end else if (hit_svc) begin
            svc_q <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (hit_wr) begin
            adr_q <= wr_addr;
            sec_q <= wr_secure;
            hdl_q <= wr_handle;
            ord_q <= wr_order;
         end
      end

      assign valid_o[s]  = vld_q;
      assign insvc_o[s]  = svc_q;
      assign secure_o[s] = sec_q;
      assign addr_o[s]   = adr_q;
      assign handle_o[s] = hdl_q;
      assign order_o[s]  = ord_q;
   end

   // R6
   wr_into_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (!valid_o[wr_idx] || (clr_en && (clr_idx == wr_idx))));

   // R9
   clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !(wr_en && (wr_idx == clr_idx))) |=> !valid_o[$past(clr_idx)]);

   // R5
   svc_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_en && !(clr_en && (clr_idx == svc_idx)) && !(wr_en && (wr_idx == svc_idx)))
      |=> insvc_o[$past(svc_idx)]);

endmodule

// File: rtl/wbq_match.sv
module wbq_match #(
   parameter int DEPTH  = 6,
   parameter int IDX_W  = 3,
   parameter int ADDR_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         probe_en,
   input  logic [ADDR_W-1:0]            probe_addr,
   input  logic                         probe_secure,
   input  logic [DEPTH-1:0]             valid,
   input  logic [DEPTH-1:0]             insvc,
   input  logic [DEPTH-1:0]             secure,
   input  logic [DEPTH-1:0][ADDR_W-1:0] addr,
   output logic                         hit,
   output logic [IDX_W-1:0]             hit_idx
);

   logic [DEPTH-1:0] same_blk;

   for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
      assign same_blk[s] = valid[s] && !insvc[s] && (secure[s] == probe_secure)
                           && (addr[s] == probe_addr);
   end

   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (probe_en && same_blk[i]) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(i);
         end
      end
   end

   // R3
   hint_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (valid[hit_idx] && !insvc[hit_idx] && (secure[hit_idx] == probe_secure)));

endmodule

// File: rtl/wbq_age_pick.sv
module wbq_age_pick #(
   parameter int DEPTH   = 6,
   parameter int IDX_W   = 3,
   parameter int ORDER_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [DEPTH-1:0]              cand,
   input  logic [DEPTH-1:0][ORDER_W-1:0] order,
   output logic                          pick_valid,
   output logic [IDX_W-1:0]              pick_idx
);

   logic [ORDER_W-1:0] best_ord;

   always_comb begin
      pick_valid = 1'b0;
      pick_idx   = '0;
      best_ord   = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cand[i] && (!pick_valid || (order[i] < best_ord))) begin
            pick_valid = 1'b1;
            pick_idx   = IDX_W'(i);
            best_ord   = order[i];
         end
      end
   end

   // R5
   pick_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid |-> cand[pick_idx]);

   for (genvar i = 0; i < DEPTH; i++) begin : g_age_chk
      // R5
      pick_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pick_valid && cand[i]) |-> (order[i] >= order[pick_idx]));
   end

endmodule

// File: rtl/wb_coalesce_q.sv
module wb_coalesce_q
   import wbq_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int BLK_BYTES  = 64,
   parameter int HANDLE_W   = 8,
   parameter int PEND_LIMIT = 4,
   parameter int SVC_SPARE  = 2,
   parameter int ORDER_W    = 16,
   localparam int DEPTH     = PEND_LIMIT + SVC_SPARE,
   localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                alloc_valid,
   input  logic [1:0]          alloc_cmd,
   input  logic [ADDR_W-1:0]   alloc_addr,
   input  logic                alloc_secure,
   input  logic [HANDLE_W-1:0] alloc_handle,
   output logic                alloc_accept,
   output logic                alloc_bad,
   output logic                merge_hint,
   output logic [IDX_W-1:0]    merge_idx,
   output logic                send_kick,
   output logic                out_valid,
   output logic [IDX_W-1:0]    out_idx,
   output logic [ADDR_W-1:0]   out_addr,
   output logic                out_secure,
   output logic [HANDLE_W-1:0] out_handle,
   output logic [ORDER_W-1:0]  out_order,
   input  logic                out_issue,
   input  logic                done_valid,
   input  logic [IDX_W-1:0]    done_idx,
   output logic                done_err,
   output logic                full,
   output logic                full_rise,
   output logic                full_fall
);

   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(BLK_BYTES - 1);

   // Elaboration-time parameter checks
   if (PEND_LIMIT < 1) begin : g_bad_limit
      $error("wb_coalesce_q: PEND_LIMIT must be at least 1");
   end
   if (SVC_SPARE < 1) begin : g_bad_spare
      $error("wb_coalesce_q: SVC_SPARE must be at least 1");
   end
   if ((BLK_BYTES < 2) || ((BLK_BYTES & (BLK_BYTES - 1)) != 0)) begin : g_bad_blk
      $error("wb_coalesce_q: BLK_BYTES must be a power of two of at least 2");
   end
   if ((ORDER_W < 4) || (HANDLE_W < 1)) begin : g_bad_width
      $error("wb_coalesce_q: ORDER_W must be 4 or more and HANDLE_W 1 or more");
   end

   logic [DEPTH-1:0]                valid;
   logic [DEPTH-1:0]                insvc;
   logic [DEPTH-1:0]                sec_v;
   logic [DEPTH-1:0][ADDR_W-1:0]    addr_v;
   logic [DEPTH-1:0][HANDLE_W-1:0]  hdl_v;
   logic [DEPTH-1:0][ORDER_W-1:0]   ord_v;
   logic [DEPTH-1:0]                waiting;

   logic [ADDR_W-1:0]  blk_addr;
   logic               cmd_ok;
   logic [CNT_W-1:0]   wait_cnt;
   logic               free_any;
   logic [IDX_W-1:0]   free_idx;
   logic               done_in_rng;
   logic               done_ok;
   logic               room;
   logic [IDX_W-1:0]   wr_idx;
   logic [ORDER_W-1:0] seq_q;
   logic               issue_fire;
   logic               full_q;

   assign blk_addr = alloc_addr & BLK_MASK;
   assign cmd_ok   = wbq_cmd_legal(alloc_cmd);
   assign waiting  = valid & ~insvc;

   always_comb begin
      wait_cnt = '0;
      for (int i = 0; i < DEPTH; i++) begin
         wait_cnt = wait_cnt + CNT_W'(waiting[i]);
      end
   end

   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!valid[i]) begin
            free_any = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   assign done_in_rng = ({1'b0, done_idx} < (IDX_W + 1)'(DEPTH));
   assign done_ok     = done_valid && done_in_rng && valid[done_idx] && insvc[done_idx];
   assign done_err    = done_valid && !done_ok;

   assign room         = wait_cnt < CNT_W'(PEND_LIMIT);
   assign alloc_bad    = alloc_valid && !cmd_ok;
   assign alloc_accept = alloc_valid && cmd_ok && room && (free_any || done_ok);
   assign send_kick    = alloc_accept;
   assign wr_idx       = free_any ? free_idx : done_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q <= '0;
      end else if (alloc_accept) begin
         seq_q <= seq_q + 1'b1;
      end
   end

   wbq_slots #(
      .DEPTH    (DEPTH),
      .IDX_W    (IDX_W),
      .ADDR_W   (ADDR_W),
      .HANDLE_W (HANDLE_W),
      .ORDER_W  (ORDER_W)
   ) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (alloc_accept),
      .wr_idx    (wr_idx),
      .wr_addr   (blk_addr),
      .wr_secure (alloc_secure),
      .wr_handle (alloc_handle),
      .wr_order  (seq_q),
      .svc_en    (issue_fire),
      .svc_idx   (out_idx),
      .clr_en    (done_ok),
      .clr_idx   (done_idx),
      .valid_o   (valid),
      .insvc_o   (insvc),
      .secure_o  (sec_v),
      .addr_o    (addr_v),
      .handle_o  (hdl_v),
      .order_o   (ord_v)
   );

   wbq_match #(
      .DEPTH  (DEPTH),
      .IDX_W  (IDX_W),
      .ADDR_W (ADDR_W)
   ) u_match (
      .clk          (clk),
      .rst_n        (rst_n),
      .probe_en     (alloc_valid && cmd_ok),
      .probe_addr   (blk_addr),
      .probe_secure (alloc_secure),
      .valid        (valid),
      .insvc        (insvc),
      .secure       (sec_v),
      .addr         (addr_v),
      .hit          (merge_hint),
      .hit_idx      (merge_idx)
   );

   wbq_age_pick #(
      .DEPTH   (DEPTH),
      .IDX_W   (IDX_W),
      .ORDER_W (ORDER_W)
   ) u_pick (
      .clk        (clk),
      .rst_n      (rst_n),
      .cand       (waiting),
      .order      (ord_v),
      .pick_valid (out_valid),
      .pick_idx   (out_idx)
   );

   assign out_addr   = addr_v[out_idx];
   assign out_secure = sec_v[out_idx];
   assign out_handle = hdl_v[out_idx];
   assign out_order  = ord_v[out_idx];
   assign issue_fire = out_issue && out_valid;

   assign full = !room || !free_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
      end else begin
         full_q <= full;
      end
   end

   assign full_rise = full && !full_q;
   assign full_fall = !full && full_q;

   // R6
   wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wait_cnt <= CNT_W'(PEND_LIMIT));

   // R7
   unblock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_fall |-> $past(issue_fire || done_ok));

   // R1
   bad_cmd_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_bad |-> !alloc_accept);

   // R6
   refuse_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !done_ok) |-> !alloc_accept);

endmodule

// File: tb/sim_wb_coalesce_q.sv
`timescale 1ns/1ps
module sim_wb_coalesce_q;

   localparam int ADDR_W = 32;
   localparam int HW     = 8;
   localparam int OW     = 16;
   localparam int IW     = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          alloc_valid = 1'b0;
   logic [1:0]    alloc_cmd = 2'b00;
   logic [ADDR_W-1:0] alloc_addr = '0;
   logic          alloc_secure = 1'b0;
   logic [HW-1:0] alloc_handle = '0;
   logic          alloc_accept, alloc_bad, merge_hint, send_kick;
   logic [IW-1:0] merge_idx;
   logic          out_valid, out_secure;
   logic [IW-1:0] out_idx;
   logic [ADDR_W-1:0] out_addr;
   logic [HW-1:0] out_handle;
   logic [OW-1:0] out_order;
   logic          out_issue = 1'b0;
   logic          done_valid = 1'b0;
   logic [IW-1:0] done_idx = '0;
   logic          done_err, full, full_rise, full_fall;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // values captured in the cycle an input is applied
   logic c_acc, c_bad, c_hint, c_kick, c_derr;
   logic [IW-1:0] c_midx;

   always #4 clk = ~clk;

   wb_coalesce_q #(
      .ADDR_W(ADDR_W), .BLK_BYTES(64), .HANDLE_W(HW),
      .PEND_LIMIT(4), .SVC_SPARE(2), .ORDER_W(OW)
   ) u0 (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_cmd(alloc_cmd), .alloc_addr(alloc_addr),
      .alloc_secure(alloc_secure), .alloc_handle(alloc_handle),
      .alloc_accept(alloc_accept), .alloc_bad(alloc_bad),
      .merge_hint(merge_hint), .merge_idx(merge_idx), .send_kick(send_kick),
      .out_valid(out_valid), .out_idx(out_idx), .out_addr(out_addr),
      .out_secure(out_secure), .out_handle(out_handle), .out_order(out_order),
      .out_issue(out_issue), .done_valid(done_valid), .done_idx(done_idx),
      .done_err(done_err), .full(full), .full_rise(full_rise), .full_fall(full_fall)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      alloc_valid = 1'b0; alloc_cmd = 2'b00; alloc_addr = '0;
      alloc_secure = 1'b0; alloc_handle = '0;
      out_issue = 1'b0; done_valid = 1'b0; done_idx = '0;
   endtask

   // Inputs already set at a falling edge; capture, clock, return at next falling edge
   task automatic step();
      #1;
      c_acc = alloc_accept; c_bad = alloc_bad; c_hint = merge_hint;
      c_midx = merge_idx; c_kick = send_kick; c_derr = done_err;
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic do_reset();
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic alloc(input logic [1:0] cmd, input logic [31:0] a,
                        input logic sec, input logic [7:0] h);
      alloc_valid = 1'b1; alloc_cmd = cmd; alloc_addr = a;
      alloc_secure = sec; alloc_handle = h;
   endtask

   task automatic issue_one();
      out_issue = 1'b1;
      step();
   endtask

   task automatic complete(input logic [IW-1:0] idx);
      done_valid = 1'b1; done_idx = idx;
      step();
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R11", "out_valid", out_valid, 0);
      chk("R11", "full", full, 0);
      chk("R11", "full_rise", full_rise, 0);
      chk("R11", "full_fall", full_fall, 0);
   endtask

   task automatic t_align_and_age();
      do_reset();
      alloc(2'b01, 32'h1234_5678, 1'b0, 8'h03); step();
      chk("R8", "send_kick on accept", c_kick, 1);
      chk("R2", "aligned addr", out_addr, 32'h1234_5640);
      chk("R4", "first order", out_order, 0);
      chk("R5", "first slot", out_idx, 0);
      alloc(2'b01, 32'h0000_0FC1, 1'b1, 8'h05); step();
      chk("R5", "still oldest", out_order, 0);
      issue_one();
      chk("R5", "next slot", out_idx, 1);
      chk("R2", "second addr", out_addr, 32'h0000_0FC0);
      chk("R4", "second order", out_order, 1);
      chk("R5", "second secure/handle", {out_secure, out_handle}, {1'b1, 8'h05});
      complete(0);
      chk("R9", "done ok", c_derr, 0);
      alloc(2'b10, 32'h0000_2000, 1'b0, 8'h07); step();
      chk("R5", "oldest in higher slot", out_idx, 1);
      issue_one();
      chk("R5", "reused low slot", out_idx, 0);
      chk("R4", "third order", out_order, 2);
   endtask

   task automatic t_merge();
      do_reset();
      alloc(2'b01, 32'h0000_1000, 1'b0, 8'h10); step();
      chk("R3", "no entries no hint", c_hint, 0);
      alloc(2'b01, 32'h0000_1010, 1'b0, 8'h11); step();
      chk("R3", "same block hint", c_hint, 1);
      chk("R3", "hint slot", c_midx, 0);
      alloc(2'b01, 32'h0000_1020, 1'b1, 8'h12); step();
      chk("R3", "secure differs", c_hint, 0);
      issue_one();
      alloc(2'b10, 32'h0000_1030, 1'b0, 8'h13); step();
      chk("R3", "skip in-service match", c_hint, 1);
      chk("R3", "waiting slot chosen", c_midx, 1);
      issue_one(); issue_one(); issue_one();
      alloc(2'b01, 32'h0000_1008, 1'b0, 8'h14); step();
      chk("R3", "only in-service matches", c_hint, 0);
   endtask

   task automatic t_bad_cmd();
      do_reset();
      alloc(2'b00, 32'h0000_4000, 1'b0, 8'h01); step();
      chk("R1", "read bad", c_bad, 1);
      chk("R1", "read not accepted", c_acc, 0);
      chk("R8", "no kick on reject", c_kick, 0);
      alloc(2'b11, 32'h0000_4000, 1'b0, 8'h01); step();
      chk("R1", "code 11 bad", c_bad, 1);
      chk("R1", "no entry made", out_valid, 0);
      alloc(2'b10, 32'h0000_4000, 1'b0, 8'h01); step();
      chk("R1", "clean evict ok", {c_acc, c_bad}, 2'b10);
      chk("R4", "rejects used no number", out_order, 0);
   endtask

   task automatic t_full_and_pair();
      do_reset();
      for (int k = 0; k < 4; k++) begin
         alloc(2'b01, 32'h0001_0000 + 32'(k * 64), 1'b0, 8'(k)); step();
         if (k == 2) chk("R6", "not full at 3", full, 0);
      end
      chk("R6", "full at limit", full, 1);
      chk("R6", "full_rise pulse", full_rise, 1);
      alloc(2'b01, 32'h0009_0000, 1'b0, 8'h99); step();
      chk("R6", "refused when full", c_acc, 0);
      chk("R6", "rise lasts one cycle", full_rise, 0);
      issue_one();
      chk("R7", "issue clears full", full, 0);
      chk("R7", "full_fall pulse", full_fall, 1);
      issue_one(); issue_one(); issue_one();
      chk("R6", "refused request left nothing", out_valid, 0);
      complete(0);
      alloc(2'b01, 32'h0002_0000, 1'b0, 8'hA0); step();
      alloc(2'b01, 32'h0002_0040, 1'b0, 8'hA1); step();
      alloc(2'b01, 32'h0002_0080, 1'b0, 8'hA2);
      done_valid = 1'b1; done_idx = 3'd1; step();
      chk("R10", "pair accepted", {c_acc, c_derr}, 2'b10);
      chk("R10", "no spurious full", {full, full_rise}, 2'b00);
      alloc(2'b01, 32'h0002_00C0, 1'b0, 8'hA3); step();
      chk("R6", "slots exhausted full", {full, full_rise}, 2'b11);
      issue_one();
      chk("R6", "still full without slot", {full, full_fall}, 2'b10);
      alloc(2'b01, 32'h0002_0100, 1'b0, 8'hA4);
      done_valid = 1'b1; done_idx = 3'd2; step();
      chk("R10", "accept into freed slot", c_acc, 1);
      chk("R10", "oldest after pair", {out_idx, out_order}, {3'd4, 16'd5});
      chk("R10", "full after pair", full, 1);
   endtask

   task automatic t_done_errors();
      do_reset();
      alloc(2'b01, 32'h0003_0000, 1'b0, 8'h33); step();
      complete(0);
      chk("R9", "done on waiting slot", c_derr, 1);
      chk("R9", "waiting entry kept", {out_valid, out_idx}, {1'b1, 3'd0});
      complete(3);
      chk("R9", "done on empty slot", c_derr, 1);
      issue_one();
      complete(0);
      chk("R9", "done in service ok", c_derr, 0);
      complete(0);
      chk("R9", "second done errors", c_derr, 1);
      alloc(2'b01, 32'h0003_0000, 1'b0, 8'h34); step();
      chk("R9", "freed slot reused", out_idx, 0);
   endtask

   initial begin
      t_reset_state();
      t_align_and_age();
      t_merge();
      t_bad_cmd();
      t_full_and_pair();
      t_done_errors();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R11 watchdog actual=timeout expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule